// File: doc/BRIEF.md
# Bus Error Monitor and Protection Register

This block sits beside a simple memory-mapped bus and judges every bus cycle while it is open. Seven external fault inputs report conditions that other logic detects. They cover an address claimed by two chip selects, a write into a read-only window, an access to a peripheral whose clock is gated off, a transfer error from a peripheral, a reserved-space violation, an external violation and a privilege (supervisor/user) violation. An eighth condition comes from inside the block: a wait counter that expires when the cycle goes unacknowledged for too long.

Each condition seen during an open cycle is recorded in a sticky status bit. Each condition also has its own enable bit. When a condition fires while its enable is set, the block ends the cycle with a one-clock access-error pulse in place of the normal acknowledge. When the enable is clear, the event is only logged, and the target's acknowledge passes through unchanged.

Software reaches two registers through one write/read port. One is a 16-bit register that holds the status byte and the enable byte. The other is a 3-bit wait-limit code.

Top module: `bus_fault_monitor`

## Requirements
- R1: After reset, register 0 reads 16'h000B (all status clear; only the timeout, external and privilege enables set), and register 1 reads 0.
- R2: Register 0 holds status in bits 15..8 and enables in bits 7..0. Both bytes use the same order, from the top bit down: overlap, read-only write, clock-off, transfer error, timeout, reserved, external, privilege. Register 1 holds the wait-limit code in bits 2..0, and its upper bits read 0. A write with `reg_sel`=0 loads the enable byte from `reg_wdata[7:0]`. A write with `reg_sel`=1 loads the code from `reg_wdata[2:0]`.
- R3: A fault input that is high during a clock with `cyc_valid` high sets its status bit at the next edge, whether or not its enable is set.
- R4: Status bits are sticky. Writing 1 to a bit of `reg_wdata[15:8]` clears that bit, and writing 0 leaves it as it is. If a set and a clear fall in the same clock, the set wins.
- R5: If an event fires in a clock while its enable is set, `bus_err` is high in that same clock and `bus_ack` stays low. The two outputs are never high together.
- R6: If the only events present have their enables clear, `bus_ack` follows `slv_ack` during the cycle and `bus_err` stays low.
- R7: The wait limit is 128 × 2^code clocks. The cycle's first clock counts as 0. If no termination has come first, the timeout event fires in clock number `limit`.
- R8: With the timeout enable clear, an expired cycle keeps waiting without termination. The timeout status still sets, and a later `slv_ack` ends the cycle normally.
- R9: The wait count restarts at 0 in the clock after each termination. Back-to-back cycles that are each acknowledged before the limit never time out, even when their total length exceeds it.
- R10: While `cyc_valid` is low, the fault inputs set no status bit and both terminations stay low.
- R11: If `slv_ack` arrives in the same clock as the timeout expiry and the timeout enable is set, the cycle ends with `bus_err` and not `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | A bus cycle is open; held until a termination is seen |
| slv_ack | input | 1 | Normal acknowledge from the addressed target |
| ev_overlap | input | 1 | Address claimed by two chip selects |
| ev_ro_write | input | 1 | Write into a read-only window |
| ev_clk_off | input | 1 | Access to a peripheral whose clock is stopped |
| ev_xfer_err | input | 1 | Peripheral access ended with a transfer error |
| ev_resv | input | 1 | Reserved-space violation |
| ev_ext | input | 1 | External violation |
| ev_priv | input | 1 | Privilege (supervisor/user) violation |
| bus_ack | output | 1 | Normal termination of the current cycle |
| bus_err | output | 1 | Access-error termination of the current cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: status/enable register, 1: wait-limit code |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected register |

## Verification
The timeout counter and the target's acknowledge can act in the same clock, and so can a fault setting a status bit while software clears that same bit. The bench makes both happen on purpose. In the first case it asserts `slv_ack` in exactly the clock where the count equals the limit, and expects `bus_err` with no `bus_ack`. In the second it raises a fault during an open cycle in the same clock that a write-1 clear targets that bit, and expects the bit to read back as still set.

// File: rtl/bfm_pkg.sv
// Package for the bus fault monitor.
// Holds the positions of the condition bits within a byte (the same order
// is used for the status byte and the enable byte) and the enable reset value.
package bfm_pkg;
    localparam int NSRC      = 8;
    localparam int REG_W     = 16;
    localparam int IX_OVLP   = 7;
    localparam int IX_ROWR   = 6;
    localparam int IX_CKOFF  = 5;
    localparam int IX_XERR   = 4;
    localparam int IX_TMO    = 3;
    localparam int IX_RESV   = 2;
    localparam int IX_EXT    = 1;
    localparam int IX_PRIV   = 0;
    localparam logic [NSRC-1:0] EN_RESET = 8'b0000_1011;
    typedef logic [NSRC-1:0] cond_vec_t;
endpackage

// File: rtl/bfm_cycle_timer.sv
// Wait counter for the bus cycle currently open.
// Counts clocks while cyc_valid is high. Restarts at 0 after any termination
// or while the bus is idle, and holds at the selected limit.
// Assumes: the limit is 2^(BASE_LOG2+tsel), so it always fits in CNT_W bits.
module bfm_cycle_timer #(
    parameter int TSEL_W    = 3,
    parameter int BASE_LOG2 = 7,
    localparam int CNT_W    = BASE_LOG2 + (1 << TSEL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              term,
    input  logic [TSEL_W-1:0] tsel,
    output logic              expired,
    output logic [CNT_W-1:0]  cnt
);
    logic [CNT_W-1:0] limit;

    // Decode the limit from the code: base times a power of two
    always_comb limit = CNT_W'(1) << (BASE_LOG2 + int'(tsel));

    // Advance, restart or hold the wait count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!cyc_valid || term) begin
            cnt <= '0;
        end else if (cnt != limit) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Expiry is reported for as long as the open cycle sits at the limit
    always_comb expired = cyc_valid && (cnt == limit);
endmodule

// File: rtl/bfm_regs.sv
// Software-visible state: sticky status byte, enable byte and wait-limit code.
// Status bits set from set_vec and clear on write-1. A set in the same clock
// as a clear wins. Read data is combinational on reg_sel.
module bfm_regs
    import bfm_pkg::*;
#(
    parameter int TSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cond_vec_t         set_vec,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output cond_vec_t         status,
    output cond_vec_t         enable,
    output logic [TSEL_W-1:0] tsel
);
    cond_vec_t clr_mask;
    logic      wr_main;
    logic      wr_tsel;

    // Split the write strobe between the two registers
    always_comb begin
        wr_main  = reg_wr && !reg_sel;
        wr_tsel  = reg_wr &&  reg_sel;
        clr_mask = wr_main ? reg_wdata[REG_W-1:NSRC] : '0;
    end

    // Sticky status: clear on write-1, then new events set
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | set_vec;
    end

    // Enable byte, written whole
    always_ff @(posedge clk) begin
        if (!rst_n)       enable <= EN_RESET;
        else if (wr_main) enable <= reg_wdata[NSRC-1:0];
    end

    // Wait-limit code
    always_ff @(posedge clk) begin
        if (!rst_n)       tsel <= '0;
        else if (wr_tsel) tsel <= reg_wdata[TSEL_W-1:0];
    end

    // Read multiplexer
    always_comb begin
        if (reg_sel) reg_rdata = {{(REG_W-TSEL_W){1'b0}}, tsel};
        else         reg_rdata = {status, enable};
    end
endmodule

// File: rtl/bfm_term.sv
// Termination decision for the open cycle.
// Gates the raw events with cyc_valid and trips the error on any enabled
// event. The normal acknowledge passes only when no enabled event is present.
// Assumes: the raw events are valid in the clock they are presented.
module bfm_term
    import bfm_pkg::*;
(
    input  logic      cyc_valid,
    input  logic      slv_ack,
    input  cond_vec_t raw_ev,
    input  cond_vec_t enable,
    output cond_vec_t set_vec,
    output logic      bus_ack,
    output logic      bus_err
);
    cond_vec_t trip;

    // Only events inside an open cycle count
    always_comb set_vec = cyc_valid ? raw_ev : '0;

    // One trip line per condition
    for (genvar i = 0; i < NSRC; i++) begin : g_trip
        assign trip[i] = set_vec[i] & enable[i];
    end

    // An enabled error overrides the normal acknowledge
    always_comb begin
        bus_err = |trip;
        bus_ack = cyc_valid && slv_ack && !bus_err;
    end
endmodule

// File: rtl/bus_fault_monitor.sv
// Bus error monitor with protection register.
// Watches the open bus cycle, records fault events in sticky status bits and
// ends the cycle with an access error when an enabled event fires.
// Assumes: the master holds cyc_valid until it sees bus_ack or bus_err.
module bus_fault_monitor
    import bfm_pkg::*;
#(
    parameter int TSEL_W    = 3,
    parameter int BASE_LOG2 = 7,
    localparam int CNT_W    = BASE_LOG2 + (1 << TSEL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_valid,
    input  logic             slv_ack,
    input  logic             ev_overlap,
    input  logic             ev_ro_write,
    input  logic             ev_clk_off,
    input  logic             ev_xfer_err,
    input  logic             ev_resv,
    input  logic             ev_ext,
    input  logic             ev_priv,
    output logic             bus_ack,
    output logic             bus_err,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    cond_vec_t         raw_ev;
    cond_vec_t         set_vec;
    cond_vec_t         status;
    cond_vec_t         enable;
    logic [TSEL_W-1:0] tsel;
    logic [CNT_W-1:0]  cnt;
    logic              expired;
    logic              term;

    // Gather the events in register bit order
    always_comb begin
        raw_ev           = '0;
        raw_ev[IX_OVLP]  = ev_overlap;
        raw_ev[IX_ROWR]  = ev_ro_write;
        raw_ev[IX_CKOFF] = ev_clk_off;
        raw_ev[IX_XERR]  = ev_xfer_err;
        raw_ev[IX_TMO]   = expired;
        raw_ev[IX_RESV]  = ev_resv;
        raw_ev[IX_EXT]   = ev_ext;
        raw_ev[IX_PRIV]  = ev_priv;
        term             = bus_ack || bus_err;
    end

    bfm_cycle_timer #(.TSEL_W(TSEL_W), .BASE_LOG2(BASE_LOG2)) u_timer (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .term(term),
        .tsel(tsel), .expired(expired), .cnt(cnt)
    );

    bfm_term u_term (
        .cyc_valid(cyc_valid), .slv_ack(slv_ack), .raw_ev(raw_ev),
        .enable(enable), .set_vec(set_vec), .bus_ack(bus_ack), .bus_err(bus_err)
    );

    bfm_regs #(.TSEL_W(TSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .status(status), .enable(enable), .tsel(tsel)
    );
endmodule

// File: rtl/bfm_checker.sv
// Property checker for bus_fault_monitor, attached by bind.
// Observes the ports plus the status, enable, code and count state.
module bfm_checker #(
    parameter int TSEL_W    = 3,
    parameter int BASE_LOG2 = 7,
    parameter int CNT_W     = BASE_LOG2 + (1 << TSEL_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_valid,
    input logic              slv_ack,
    input logic              ev_overlap,
    input logic              ev_ro_write,
    input logic              bus_ack,
    input logic              bus_err,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [7:0]        clr_bits,
    input logic [7:0]        status,
    input logic [7:0]        enable,
    input logic [TSEL_W-1:0] tsel,
    input logic [CNT_W-1:0]  cnt
);
    logic [7:0]       clr_seen;
    logic [CNT_W-1:0] lim_chk;

    // Clear mask as software requests it, and the limit as software selects it
    always_comb begin
        clr_seen = (reg_wr && !reg_sel) ? clr_bits : 8'h00;
        lim_chk  = CNT_W'(1) << (BASE_LOG2 + int'(tsel));
    end

    assert_single_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_err));

    assert_overlap_trips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && ev_overlap && enable[7]) |-> bus_err);

    assert_ack_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && slv_ack && enable == 8'h00) |-> bus_ack);

    assert_ro_logged_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && ev_ro_write) |=> status[6]);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(clr_seen) & ~status) == 8'h00));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |-> (!bus_ack && !bus_err));

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim_chk);

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack || bus_err) |=> (cnt == '0));
endmodule

bind bus_fault_monitor bfm_checker #(.TSEL_W(TSEL_W), .BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .slv_ack(slv_ack),
    .ev_overlap(ev_overlap), .ev_ro_write(ev_ro_write), .bus_ack(bus_ack),
    .bus_err(bus_err), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .clr_bits(reg_wdata[15:8]), .status(status), .enable(enable),
    .tsel(tsel), .cnt(cnt)
);

// File: tb/sim_bus_fault_monitor.sv
module sim_bus_fault_monitor;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0, slv_ack = 1'b0;
    logic        ev_overlap = 1'b0, ev_ro_write = 1'b0, ev_clk_off = 1'b0, ev_xfer_err = 1'b0;
    logic        ev_resv = 1'b0, ev_ext = 1'b0, ev_priv = 1'b0;
    logic        bus_ack, bus_err;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_fault_monitor u0 (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .slv_ack(slv_ack),
        .ev_overlap(ev_overlap), .ev_ro_write(ev_ro_write), .ev_clk_off(ev_clk_off),
        .ev_xfer_err(ev_xfer_err), .ev_resv(ev_resv), .ev_ext(ev_ext), .ev_priv(ev_priv),
        .bus_ack(bus_ack), .bus_err(bus_err), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Table entry: {source index[2:0], enables[7:0], slv_ack, exp_err, exp_ack}
    localparam logic [13:0] VEC [0:8] = '{
        {3'd7, 8'h80, 1'b1, 1'b1, 1'b0},
        {3'd7, 8'h00, 1'b1, 1'b0, 1'b1},
        {3'd6, 8'h40, 1'b1, 1'b1, 1'b0},
        {3'd5, 8'h00, 1'b1, 1'b0, 1'b1},
        {3'd4, 8'h10, 1'b0, 1'b1, 1'b0},
        {3'd2, 8'h04, 1'b1, 1'b1, 1'b0},
        {3'd1, 8'h00, 1'b1, 1'b0, 1'b1},
        {3'd0, 8'h01, 1'b0, 1'b1, 1'b0},
        {3'd0, 8'hFE, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        #1;
    endtask

    task automatic set_src(input int idx, input logic v);
        case (idx)
            7: ev_overlap  = v;
            6: ev_ro_write = v;
            5: ev_clk_off  = v;
            4: ev_xfer_err = v;
            2: ev_resv     = v;
            1: ev_ext      = v;
            0: ev_priv     = v;
            default: ;
        endcase
    endtask

    task automatic drop_all;
        cyc_valid = 1'b0; slv_ack = 1'b0;
        for (int k = 0; k < 8; k++) set_src(k, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic quiet;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset values
        reg_sel = 1'b0; #1 chk("R1 reg0", reg_rdata, 16'h000B);
        reg_sel = 1'b1; #1 chk("R1 reg1", reg_rdata, 16'h0000);
        reg_sel = 1'b0;

        // R2 R3 R5 R6 table walk
        for (int i = 0; i < 9; i++) begin
            wr_reg(1'b0, {8'hFF, VEC[i][10:3]});
            @(negedge clk);
            cyc_valid = 1'b1; slv_ack = VEC[i][2];
            set_src(int'(VEC[i][13:11]), 1'b1);
            #1;
            chk("R5 R6 err", {15'd0, bus_err}, {15'd0, VEC[i][1]});
            chk("R5 R6 ack", {15'd0, bus_ack}, {15'd0, VEC[i][0]});
            @(negedge clk);
            drop_all(); #1;
            chk("R2 R3 status", reg_rdata, {8'(1 << VEC[i][13:11]), VEC[i][10:3]});
        end

        // R2 R7 code 1: limit 256
        wr_reg(1'b0, 16'hFF08);
        wr_reg(1'b1, 16'h0001);
        reg_sel = 1'b1; #1 chk("R2 code readback", reg_rdata, 16'h0001); reg_sel = 1'b0;
        @(negedge clk); cyc_valid = 1'b1;
        repeat (255) @(negedge clk);
        #1 chk("R7 before limit 256", {15'd0, bus_err}, 16'h0000);
        @(negedge clk); #1 chk("R7 at limit 256", {14'd0, bus_err, bus_ack}, 16'h0002);
        @(negedge clk); drop_all(); #1;
        chk("R7 timeout status", reg_rdata, 16'h0808);

        // R7 R11 code 0: limit 128, ack collides with expiry
        wr_reg(1'b0, 16'hFF08);
        wr_reg(1'b1, 16'h0000);
        @(negedge clk); cyc_valid = 1'b1;
        repeat (127) @(negedge clk);
        #1 chk("R7 before limit 128", {15'd0, bus_err}, 16'h0000);
        @(negedge clk); slv_ack = 1'b1;
        #1 chk("R11 err wins over ack", {14'd0, bus_err, bus_ack}, 16'h0002);
        @(negedge clk); drop_all();

        // R8 timeout disabled: wait past the limit, then ack
        wr_reg(1'b0, 16'hFF00);
        @(negedge clk); cyc_valid = 1'b1;
        quiet = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); #1;
            if (bus_err || bus_ack) quiet = 1'b0;
        end
        chk("R8 no termination", {15'd0, quiet}, 16'h0001);
        chk("R8 status set", reg_rdata, 16'h0800);
        slv_ack = 1'b1; #1;
        chk("R8 late ack", {14'd0, bus_err, bus_ack}, 16'h0001);
        @(negedge clk); drop_all();

        // R9 back-to-back cycles below the limit
        wr_reg(1'b0, 16'hFF08);
        @(negedge clk); cyc_valid = 1'b1;
        repeat (100) @(negedge clk);
        slv_ack = 1'b1; #1 chk("R9 first ack", {14'd0, bus_err, bus_ack}, 16'h0001);
        @(negedge clk); slv_ack = 1'b0;
        repeat (100) @(negedge clk);
        #1 chk("R9 no timeout", {15'd0, bus_err}, 16'h0000);
        slv_ack = 1'b1; #1 chk("R9 second ack", {14'd0, bus_err, bus_ack}, 16'h0001);
        @(negedge clk); drop_all(); #1;
        chk("R9 status clear", reg_rdata, 16'h0008);

        // R10 faults while idle
        wr_reg(1'b0, 16'hFFFF);
        @(negedge clk);
        for (int k = 0; k < 8; k++) set_src(k, 1'b1);
        #1 chk("R10 idle terminations", {14'd0, bus_err, bus_ack}, 16'h0000);
        @(negedge clk); drop_all(); #1;
        chk("R10 status untouched", reg_rdata, 16'h00FF);

        // R4 set and clear in the same clock, then write-0 and write-1
        wr_reg(1'b0, 16'hFF00);
        @(negedge clk);
        cyc_valid = 1'b1; ev_overlap = 1'b1; slv_ack = 1'b1;
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h8000;
        @(negedge clk);
        drop_all(); reg_wr = 1'b0; reg_wdata = '0; #1;
        chk("R4 set beats clear", reg_rdata, 16'h8000);
        wr_reg(1'b0, 16'h0000);
        chk("R4 write-0 keeps", reg_rdata, 16'h8000);
        wr_reg(1'b0, 16'h8000);
        chk("R4 write-1 clears", reg_rdata, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule